// File: doc/BRIEF.md
# Speculative Load Buffer with Visibility-Point Checking

Each core has one of these buffers. It keeps the address and data of every load that was served without touching the cache hierarchy. There is one entry for each in-flight load ID. When the pipeline fills an entry, the entry becomes held. Later the pipeline tells the buffer that the load has reached its visibility point, and with that trigger it says which of two finishing paths the load takes.

In the checked path, the entry sends a state-changing memory request and waits for fresh data. It compares that data with its stored copy. A match makes the load retirable. A mismatch raises a one-cycle squash for that load ID and frees the entry. In the uncompared path, the entry sends the same kind of request and becomes retirable in the cycle after the request is accepted. Nothing comes back for it.

Only one request leaves per cycle, and the lowest pending load ID goes first. A pipeline flush drops every entry that has not yet finished checking. Responses that arrive later for those dropped entries are thrown away. A retire pulse frees a finished entry so that its ID can be used again.

Top module: `spec_load_buf`

## Requirements
- R1: After a synchronous active-low reset, every entry is idle: `retire_ready_o` is all zeros, `mem_req_valid_o` is 0 and `squash_valid_o` is 0.
- R2: An allocate pulse to an idle entry stores the address and data and makes the entry held. An allocate pulse to an entry that is not idle leaves its stored address and data unchanged.
- R3: A visibility pulse to a held entry makes it request the memory port from the next cycle on. The request carries the entry's ID and stored address. `mem_req_expose_o` is 1 when `vis_validate_i` was 0 (uncompared path) and 0 when it was 1 (checked path). A visibility pulse to an entry that is not held has no effect.
- R4: When an uncompared request is accepted (`mem_req_valid_o` and `mem_req_ready_i` both 1), the entry's `retire_ready_o` bit is 1 from the next cycle on, with no response needed.
- R5: When a checked request is accepted, the entry's `retire_ready_o` bit stays 0 until a response with that load ID arrives.
- R6: A response whose data equals the stored data sets the entry's `retire_ready_o` bit in the next cycle and raises no squash.
- R7: A response whose data differs from the stored data raises `squash_valid_o` for exactly one cycle, in the next cycle, with `squash_id_o` equal to the load ID. The entry goes back to idle.
- R8: When several entries request in the same cycle, `mem_req_id_o` is the lowest requesting ID. A request that is not accepted stays asserted.
- R9: A flush pulse sends every entry that is not retire-ready to idle and keeps the retire-ready ones. `mem_req_valid_o` is 0 in the cycle that flush is high.
- R10: A response for an entry that is not waiting on a checked request is dropped. It sets no `retire_ready_o` bit and raises no squash.
- R11: A retire pulse to a retire-ready entry clears its `retire_ready_o` bit in the next cycle, and the ID can then be allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Pipeline flush pulse |
| alloc_valid_i | input | 1 | Invisible-load data write pulse |
| alloc_id_i | input | IDX_W | Load ID being written |
| alloc_addr_i | input | ADDR_W | Load address |
| alloc_data_i | input | DATA_W | Data returned by the invisible load |
| vis_valid_i | input | 1 | Visibility-point pulse |
| vis_id_i | input | IDX_W | Load ID reaching its visibility point |
| vis_validate_i | input | 1 | 1 selects the checked path, 0 the uncompared path |
| retire_valid_i | input | 1 | Retire pulse that frees an entry |
| retire_id_i | input | IDX_W | Load ID being retired |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory side accepts the request |
| mem_req_id_o | output | IDX_W | Load ID of the request |
| mem_req_addr_o | output | ADDR_W | Address of the request |
| mem_req_expose_o | output | 1 | 1 means no response is expected |
| mem_rsp_valid_i | input | 1 | Fresh-data response valid |
| mem_rsp_id_i | input | IDX_W | Load ID of the response |
| mem_rsp_data_i | input | DATA_W | Fresh data |
| retire_ready_o | output | NUM_ENTRIES | One bit per entry, set when that load may retire |
| squash_valid_o | output | 1 | Mismatch squash pulse |
| squash_id_o | output | IDX_W | Load ID to squash |

## Verification
The embedded assertions check several things on every cycle:
- the move an entry makes when its request is accepted (to retire-ready on the uncompared path, to waiting on the checked path);
- the flush clearing non-ready entries;
- a ready entry holding until it is retired;
- the arbiter granting at most one requester and only a requester;
- at most one squash source at a time.

Three properties need the bench's scenarios:
- that a bypassed allocate keeps the original data, shown through a later compare;
- that the lowest ID wins when requests are made at staggered times;
- that a late response after a flush is dropped.

The bench's behavioural model covers these, and it also tracks the exact cycle in which each retire-ready bit and each squash pulse appears.

// File: rtl/sbuf_pkg.sv
// Package: shared state encoding for the speculative load buffer.
// Assumes nothing beyond a 2-bit state field per entry.
package sbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_HELD       = 2'd1,
        ST_VALIDATING = 2'd2,
        ST_DONE       = 2'd3
    } ent_state_e;
endpackage

// File: rtl/sbuf_prio_arb.sv
// Fixed-priority arbiter: grants the lowest-index requester.
// Assumes the caller gates the grant with the downstream ready.
module sbuf_prio_arb #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic [N-1:0]     gnt_o,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Pick the lowest set request bit.
    always_comb begin
        gnt_o = '0;
        any_o = 1'b0;
        idx_o = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                gnt_o    = '0;
                gnt_o[k] = 1'b1;
                any_o    = 1'b1;
                idx_o    = IDX_W'(k);
            end
        end
    end

    p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_o) && ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/sbuf_entry.sv
// One buffer entry: holds the invisible-load address and data, then follows
// either the checked path (request, wait, compare) or the uncompared path
// (request, retire-ready on acceptance). Assumes the top decodes IDs and
// that grant_i is only high when this entry's request is accepted.
module sbuf_entry
    import sbuf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              alloc_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [DATA_W-1:0] alloc_data_i,
    input  logic              vis_i,
    input  logic              vis_validate_i,
    input  logic              retire_i,
    input  logic              grant_i,
    input  logic              rsp_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output ent_state_e        state_o,
    output logic              want_o,
    output logic              expose_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              squash_o
);
    ent_state_e        state_q;
    logic              pend_q;
    logic              chk_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              squash_q;

    // Entry state machine, storage and squash pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pend_q   <= 1'b0;
            chk_q    <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            squash_q <= 1'b0;
        end else begin
            squash_q <= 1'b0;
            if (flush_i) begin
                if (state_q != ST_DONE) begin
                    state_q <= ST_IDLE;
                    pend_q  <= 1'b0;
                end
            end else begin
                case (state_q)
                    ST_IDLE: begin
                        if (alloc_i) begin
                            state_q <= ST_HELD;
                            addr_q  <= alloc_addr_i;
                            data_q  <= alloc_data_i;
                            pend_q  <= 1'b0;
                        end
                    end
                    ST_HELD: begin
                        if (pend_q) begin
                            if (grant_i) begin
                                state_q <= chk_q ? ST_VALIDATING : ST_DONE;
                                pend_q  <= 1'b0;
                            end
                        end else if (vis_i) begin
                            pend_q <= 1'b1;
                            chk_q  <= vis_validate_i;
                        end
                    end
                    ST_VALIDATING: begin
                        if (rsp_i) begin
                            if (rsp_data_i == data_q) begin
                                state_q <= ST_DONE;
                            end else begin
                                state_q  <= ST_IDLE;
                                squash_q <= 1'b1;
                            end
                        end
                    end
                    default: begin
                        if (retire_i) state_q <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // Drive request and status outputs from held state.
    always_comb begin
        state_o  = state_q;
        want_o   = (state_q == ST_HELD) && pend_q;
        expose_o = !chk_q;
        addr_o   = addr_q;
        squash_o = squash_q;
    end

    p_expose_retire_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !chk_q && !flush_i) |=> (state_q == ST_DONE));
    p_validate_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && chk_q && !flush_i) |=> (state_q == ST_VALIDATING));
    p_flush_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_i && state_q != ST_DONE) |=> (state_q == ST_IDLE));
    p_done_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !retire_i) |=> (state_q == ST_DONE));
    p_grant_needs_want_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grant_i |-> want_o);
endmodule

// File: rtl/spec_load_buf.sv
// Speculative load buffer: one entry per load ID, fixed-priority access
// to one memory request port, compare-on-response for checked loads.
// Assumes at most one response per cycle and that the pipeline keeps
// IDs unique among live loads.
module spec_load_buf
    import sbuf_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 64,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   flush_i,
    input  logic                   alloc_valid_i,
    input  logic [IDX_W-1:0]       alloc_id_i,
    input  logic [ADDR_W-1:0]      alloc_addr_i,
    input  logic [DATA_W-1:0]      alloc_data_i,
    input  logic                   vis_valid_i,
    input  logic [IDX_W-1:0]       vis_id_i,
    input  logic                   vis_validate_i,
    input  logic                   retire_valid_i,
    input  logic [IDX_W-1:0]       retire_id_i,
    output logic                   mem_req_valid_o,
    input  logic                   mem_req_ready_i,
    output logic [IDX_W-1:0]       mem_req_id_o,
    output logic [ADDR_W-1:0]      mem_req_addr_o,
    output logic                   mem_req_expose_o,
    input  logic                   mem_rsp_valid_i,
    input  logic [IDX_W-1:0]       mem_rsp_id_i,
    input  logic [DATA_W-1:0]      mem_rsp_data_i,
    output logic [NUM_ENTRIES-1:0] retire_ready_o,
    output logic                   squash_valid_o,
    output logic [IDX_W-1:0]       squash_id_o
);
    logic [NUM_ENTRIES-1:0] want_vec;
    logic [NUM_ENTRIES-1:0] gnt_vec;
    logic [NUM_ENTRIES-1:0] expose_vec;
    logic [NUM_ENTRIES-1:0] squash_vec;
    logic [ADDR_W-1:0]      ent_addr [NUM_ENTRIES];
    ent_state_e             ent_state [NUM_ENTRIES];
    logic                   arb_any;
    logic [IDX_W-1:0]       arb_idx;

    sbuf_prio_arb #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (want_vec),
        .gnt_o (gnt_vec),
        .any_o (arb_any),
        .idx_o (arb_idx)
    );

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_ID = IDX_W'(i);
        logic accept;
        assign accept = gnt_vec[i] && mem_req_ready_i && !flush_i;

        sbuf_entry #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ent (
            .clk            (clk),
            .rst_n          (rst_n),
            .flush_i        (flush_i),
            .alloc_i        (alloc_valid_i && alloc_id_i == MY_ID),
            .alloc_addr_i   (alloc_addr_i),
            .alloc_data_i   (alloc_data_i),
            .vis_i          (vis_valid_i && vis_id_i == MY_ID),
            .vis_validate_i (vis_validate_i),
            .retire_i       (retire_valid_i && retire_id_i == MY_ID),
            .grant_i        (accept),
            .rsp_i          (mem_rsp_valid_i && mem_rsp_id_i == MY_ID),
            .rsp_data_i     (mem_rsp_data_i),
            .state_o        (ent_state[i]),
            .want_o         (want_vec[i]),
            .expose_o       (expose_vec[i]),
            .addr_o         (ent_addr[i]),
            .squash_o       (squash_vec[i])
        );
        assign retire_ready_o[i] = (ent_state[i] == ST_DONE);
    end

    // Memory request port: granted entry, held off during a flush.
    always_comb begin
        mem_req_valid_o  = arb_any && !flush_i;
        mem_req_id_o     = arb_idx;
        mem_req_addr_o   = ent_addr[arb_idx];
        mem_req_expose_o = expose_vec[arb_idx];
    end

    // Encode the squashing entry's ID.
    always_comb begin
        squash_valid_o = |squash_vec;
        squash_id_o    = '0;
        for (int k = 0; k < NUM_ENTRIES; k++) begin
            if (squash_vec[k]) squash_id_o = IDX_W'(k);
        end
    end

    p_squash_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(squash_vec));
    p_squash_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_valid_o && !mem_rsp_valid_i) |=> !squash_valid_o);
endmodule

// File: tb/spec_load_buf_tb.sv
module spec_load_buf_tb;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int AW = 32;
    localparam int DW = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, alloc_v = 0, vis_v = 0, vis_chk = 0, ret_v = 0;
    logic [IW-1:0] alloc_id = 0, vis_id = 0, ret_id = 0, rsp_id = 0;
    logic [AW-1:0] alloc_addr = 0;
    logic [DW-1:0] alloc_data = 0, rsp_data = 0;
    logic rdy = 1'b1, rsp_v = 0;
    logic req_v, req_exp, sq_v;
    logic [IW-1:0] req_id, sq_id;
    logic [AW-1:0] req_addr;
    logic [N-1:0]  rr;

    int checks = 0, errors = 0, cycles = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    spec_load_buf #(.NUM_ENTRIES(N), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush),
        .alloc_valid_i(alloc_v), .alloc_id_i(alloc_id), .alloc_addr_i(alloc_addr),
        .alloc_data_i(alloc_data), .vis_valid_i(vis_v), .vis_id_i(vis_id),
        .vis_validate_i(vis_chk), .retire_valid_i(ret_v), .retire_id_i(ret_id),
        .mem_req_valid_o(req_v), .mem_req_ready_i(rdy), .mem_req_id_o(req_id),
        .mem_req_addr_o(req_addr), .mem_req_expose_o(req_exp),
        .mem_rsp_valid_i(rsp_v), .mem_rsp_id_i(rsp_id), .mem_rsp_data_i(rsp_data),
        .retire_ready_o(rr), .squash_valid_o(sq_v), .squash_id_o(sq_id)
    );

    // Behavioural reference: 0 idle, 1 held, 2 waiting, 3 ready.
    int            ms [N];
    bit            mp [N];
    bit            mc [N];
    logic [AW-1:0] ma [N];
    logic [DW-1:0] md [N];
    bit            msq;
    int            msqid;

    function automatic int m_pick();
        for (int i = 0; i < N; i++) if (ms[i] == 1 && mp[i]) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin ms[i] = 0; mp[i] = 0; mc[i] = 0; end
            msq = 0; msqid = 0;
        end else begin
            int g;
            g = m_pick();
            msq = 0;
            for (int i = 0; i < N; i++) begin
                if (flush) begin
                    if (ms[i] != 3) begin ms[i] = 0; mp[i] = 0; end
                end else if (ms[i] == 0) begin
                    if (alloc_v && alloc_id == i) begin
                        ms[i] = 1; ma[i] = alloc_addr; md[i] = alloc_data; mp[i] = 0;
                    end
                end else if (ms[i] == 1) begin
                    if (mp[i]) begin
                        if (g == i && rdy) begin ms[i] = mc[i] ? 2 : 3; mp[i] = 0; end
                    end else if (vis_v && vis_id == i) begin
                        mp[i] = 1; mc[i] = vis_chk;
                    end
                end else if (ms[i] == 2) begin
                    if (rsp_v && rsp_id == i) begin
                        if (rsp_data == md[i]) ms[i] = 3;
                        else begin ms[i] = 0; msq = 1; msqid = i; end
                    end
                end else begin
                    if (ret_v && ret_id == i) ms[i] = 0;
                end
            end
        end
    end

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison against the reference model.
    always @(negedge clk) begin
        if (cmp_on) begin
            int g;
            logic [N-1:0] er;
            g = m_pick();
            for (int i = 0; i < N; i++) er[i] = (ms[i] == 3);
            check(req_v, (g >= 0 && !flush), "R8 R9 req valid");
            if (g >= 0 && !flush) begin
                check(req_id, g, "R8 req id");
                check(req_addr, ma[g], "R3 req addr");
                check(req_exp, !mc[g], "R3 req expose");
            end
            check(rr, er, "R4 R5 R6 retire ready");
            check(sq_v, msq, "R7 squash valid");
            if (msq) check(sq_id, msqid, "R7 squash id");
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic do_alloc(input int id, input logic [AW-1:0] a, input logic [DW-1:0] d);
        alloc_v = 1; alloc_id = IW'(id); alloc_addr = a; alloc_data = d;
        tick();
        alloc_v = 0;
    endtask

    task automatic do_vis(input int id, input logic chk);
        vis_v = 1; vis_id = IW'(id); vis_chk = chk;
        tick();
        vis_v = 0;
    endtask

    task automatic do_rsp(input int id, input logic [DW-1:0] d);
        rsp_v = 1; rsp_id = IW'(id); rsp_data = d;
        tick();
        rsp_v = 0;
    endtask

    task automatic do_retire(input int id);
        ret_v = 1; ret_id = IW'(id);
        tick();
        ret_v = 0;
    endtask

    initial begin
        tick(); tick(); tick();
        rst_n = 1;
        cmp_on = 1;
        check(rr, 0, "R1 retire ready after reset");
        check(req_v, 0, "R1 no request after reset");
        check(sq_v, 0, "R1 no squash after reset");

        // R2: allocation, second write to a held entry ignored.
        do_alloc(2, 32'h100, 64'hAAAA);
        do_alloc(5, 32'h200, 64'h5555);
        do_alloc(2, 32'h999, 64'hDEAD);

        // R3/R4: uncompared path.
        do_vis(2, 1'b0);
        check(req_v, 1, "R3 request after visibility");
        check(req_id, 2, "R3 request id");
        check(req_addr, 32'h100, "R2 original address kept");
        check(req_exp, 1, "R3 expose flag");
        tick();
        check(rr[2], 1, "R4 retire ready after acceptance");

        // R5/R6: checked path with a stalled port.
        rdy = 0;
        do_vis(5, 1'b1);
        check(req_exp, 0, "R3 validate flag");
        tick(); tick();
        check(req_v, 1, "R8 request held while not ready");
        check(rr[5], 0, "R5 not ready while stalled");
        rdy = 1;
        tick();
        check(req_v, 0, "R5 request accepted");
        tick(); tick(); tick();
        check(rr[5], 0, "R5 waiting for response");
        do_rsp(5, 64'h5555);
        check(rr[5], 1, "R6 match makes retire ready");
        check(sq_v, 0, "R6 no squash on match");

        // R8: lowest ID wins.
        rdy = 0;
        do_alloc(3, 32'h300, 64'h33);
        do_alloc(1, 32'h180, 64'h11);
        do_vis(3, 1'b1);
        check(req_id, 3, "R8 single requester");
        do_vis(1, 1'b1);
        check(req_id, 1, "R8 lower id wins");
        rdy = 1;
        tick();
        check(req_id, 3, "R8 next requester");
        tick();
        check(req_v, 0, "R8 all accepted");

        // R7: mismatch squash.
        do_rsp(1, 64'h12);
        check(sq_v, 1, "R7 squash raised");
        check(sq_id, 1, "R7 squash id");
        check(rr[1], 0, "R7 no retire on mismatch");
        tick();
        check(sq_v, 0, "R7 squash one cycle");
        do_rsp(3, 64'h33);
        check(rr[3], 1, "R6 second match");

        // R10: response to an idle entry dropped.
        do_rsp(6, 64'h0);
        check(rr[6], 0, "R10 stray response ignored");
        check(sq_v, 0, "R10 no squash from stray");

        // R3: visibility on idle or ready entries ignored.
        do_vis(0, 1'b1);
        check(req_v, 0, "R3 vis on idle ignored");
        do_vis(2, 1'b1);
        check(req_v, 0, "R3 vis on ready ignored");

        // R9: flush.
        do_alloc(4, 32'h400, 64'h44);
        do_alloc(6, 32'h600, 64'h66);
        do_vis(4, 1'b1);
        tick();
        rdy = 0;
        do_vis(6, 1'b0);
        check(req_id, 6, "R9 pending before flush");
        flush = 1;
        #1;
        check(req_v, 0, "R9 no request during flush");
        tick();
        flush = 0;
        check(rr, 8'b0010_1100, "R9 ready entries kept");
        check(req_v, 0, "R9 pending request cleared");
        rdy = 1;
        do_rsp(4, 64'h44);
        check(rr[4], 0, "R10 late response after flush dropped");
        check(sq_v, 0, "R10 no squash after flush");

        // R11: retire frees the entry for reuse.
        do_retire(2);
        check(rr[2], 0, "R11 retire clears ready");
        do_alloc(2, 32'h110, 64'h22);
        do_vis(2, 1'b0);
        check(req_addr, 32'h110, "R11 reused entry address");
        tick();
        check(rr[2], 1, "R11 reused entry ready");
        tick(); tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule